// File: doc/BRIEF.md
# Sync Character Hunt Detector

This block is the character-level hunt stage of a serial receiver that runs in character-oriented synchronous modes. A bit assembler upstream presents one received character at a time with a valid strobe. While the channel is hunting, the block compares each character against one or two programmed sync characters. It decides for every character whether the receive buffer should take it or discard it. When the programmed sync sequence has been seen, the block reports that character framing has been reached.

Software starts the hunt by writing a control word with both the receiver-enable bit and the enter-hunt bit set. The channel then drives its sync output active and throws characters away until a match is found. In the two-character mode, a mismatch on the second character sends the search back to the first sync character. Once sync is reached, every later character goes straight through with no comparison, until the next hunt command. An optional setting drops the character that completes sync instead of forwarding it.

Top module: `sync_hunt`

## Requirements
- R1: A control write with bit 0 and bit 4 of `ctrlData` both set starts the hunt when `modeField` is a synchronous mode. In the next cycle `inHunt` is 1 and `syncPinN` is 0. A write with only one of the two bits set leaves the block idle.
- R2: When `modeField` = 4'b0000 (one-character sync), every character that differs from `syncChar1` is discarded and the hunt continues. A character equal to `syncChar1` ends the hunt.
- R3: When `modeField` = 4'b0100 (two-character sync), a character equal to `syncChar1` is discarded and the block moves on to wait for `syncChar2`. A following character equal to `syncChar2` ends the hunt.
- R4: In the two-character mode, if the character after a `syncChar1` match differs from `syncChar2`, it is discarded and the hunt returns to looking for `syncChar1`. That character is not itself compared with `syncChar1`.
- R5: The character that ends the hunt is forwarded when `dropSync` is 0 and discarded when `dropSync` is 1.
- R6: When the hunt ends, `syncPinN` returns to 1 and `inHunt` to 0. `statIrq` is a one-cycle pulse in the cycle after the completing character, and it occurs only if `statPending` was 0.
- R7: Outside a hunt, every character is forwarded and `fwdChar` equals the received character.
- R8: Each `rxValid` produces exactly one of `fwdValid` or `dropValid` in the following cycle. Neither is ever asserted without a preceding `rxValid`.
- R9: A `chanReset` pulse, or a `modeField` value other than 4'b0000 or 4'b0100, returns the block to idle by the next cycle with `syncPinN` = 1. A hunt command in such a mode is ignored.
- R10: When a character and a hunt command arrive in the same cycle, the character is judged by the state held before the command, and the hunt is active in the next cycle.
- R11: After reset, `inHunt` = 0, `syncPinN` = 1, and `fwdValid`, `dropValid` and `statIrq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chanReset | input | 1 | Channel reset strobe, forces idle |
| modeField | input | 4 | Sync mode field: 0000 one-char, 0100 two-char, other not char-sync |
| ctrlWe | input | 1 | Control register write strobe |
| ctrlData | input | 8 | Control write data; bit 0 receiver enable, bit 4 enter hunt |
| syncChar1 | input | 8 | First sync character |
| syncChar2 | input | 8 | Second sync character |
| dropSync | input | 1 | Discard the character that completes sync |
| statPending | input | 1 | A status interrupt is already pending |
| rxValid | input | 1 | Received character strobe |
| rxChar | input | 8 | Received character |
| inHunt | output | 1 | Channel is hunting for sync |
| syncPinN | output | 1 | Sync output, active low while hunting |
| statIrq | output | 1 | One-cycle status interrupt on sync acquisition |
| fwdValid | output | 1 | Character goes to the receive buffer |
| dropValid | output | 1 | Character is discarded |
| fwdChar | output | 8 | Forwarded character |

## Verification
Every result is registered once. The forward or discard decision, the interrupt pulse and the new hunt flag and sync output all appear in the cycle after the edge that captured the stimulus. The bench drives inputs on the falling edge and holds them across one rising edge. It samples the outputs on the following falling edge, when those registers carry the result for exactly that stimulus. The one-cycle width of the interrupt is checked one more falling edge later. Same-cycle character and hunt-command collisions are driven within a single cycle, so the old-state decision and the new hunt flag are read together.

// File: rtl/sync_hunt_pkg.sv
package sync_hunt_pkg;

  typedef enum logic [1:0] {
    HUNT_IDLE   = 2'd0,
    HUNT_FIRST  = 2'd1,
    HUNT_SECOND = 2'd2
  } huntState_e;

  // strobes sent from control to datapath, one set per cycle
  typedef struct packed {
    logic fwd;
    logic drop;
    logic irq;
  } huntStrobe_t;

  localparam logic [3:0] MODE_MONO = 4'b0000;
  localparam logic [3:0] MODE_BI   = 4'b0100;

endpackage

// File: rtl/sync_hunt_ctrl.sv
module sync_hunt_ctrl
  import sync_hunt_pkg::*;
#(
  parameter int ctrlW     = 8,
  parameter int enableBit = 0,
  parameter int huntBit   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chanReset,
  input  logic [3:0]       modeField,
  input  logic             ctrlWe,
  input  logic [ctrlW-1:0] ctrlData,
  input  logic             dropSync,
  input  logic             statPending,
  input  logic             rxValid,
  input  logic             match1,
  input  logic             match2,
  output huntStrobe_t      strobe,
  output logic             inHunt,
  output logic             syncPinN
);

  huntState_e state, nextState;
  logic isSync, isBi, huntReq;

  assign isBi    = (modeField == MODE_BI);
  assign isSync  = (modeField == MODE_MONO) || isBi;
  assign huntReq = ctrlWe && ctrlData[enableBit] && ctrlData[huntBit];

  always_comb begin
    strobe    = '0;
    nextState = state;
    // the received character is judged by the current state first
    if (rxValid) begin
      unique case (state)
        HUNT_IDLE: strobe.fwd = 1'b1;
        HUNT_FIRST: begin
          if (match1 && isBi) begin
            strobe.drop = 1'b1;
            nextState   = HUNT_SECOND;
          end else if (match1) begin
            strobe.fwd  = !dropSync;
            strobe.drop = dropSync;
            strobe.irq  = !statPending;
            nextState   = HUNT_IDLE;
          end else begin
            strobe.drop = 1'b1;
          end
        end
        HUNT_SECOND: begin
          if (match2) begin
            strobe.fwd  = !dropSync;
            strobe.drop = dropSync;
            strobe.irq  = !statPending;
            nextState   = HUNT_IDLE;
          end else begin
            strobe.drop = 1'b1;
            nextState   = HUNT_FIRST;
          end
        end
        default: strobe.fwd = 1'b1;
      endcase
    end
    // commands override afterwards
    if (chanReset || !isSync) begin
      nextState = HUNT_IDLE;
    end else if (huntReq) begin
      nextState = HUNT_FIRST;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= HUNT_IDLE;
      syncPinN <= 1'b1;
    end else begin
      state    <= nextState;
      syncPinN <= (nextState == HUNT_IDLE);
    end
  end

  assign inHunt = (state != HUNT_IDLE);

  // R1
  hunt_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (huntReq && isSync && !chanReset) |=> (inHunt && !syncPinN));

  // R9
  leave_to_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chanReset || !isSync) |=> (!inHunt && syncPinN));

  // R4
  second_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == HUNT_SECOND && rxValid && !match2 && !chanReset && isSync && !huntReq)
      |=> (state == HUNT_FIRST));

endmodule

// File: rtl/sync_hunt_datapath.sv
module sync_hunt_datapath
  import sync_hunt_pkg::*;
#(
  parameter int charW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxValid,
  input  logic [charW-1:0] rxChar,
  input  logic [charW-1:0] syncChar1,
  input  logic [charW-1:0] syncChar2,
  input  huntStrobe_t      strobe,
  output logic             match1,
  output logic             match2,
  output logic             fwdValid,
  output logic             dropValid,
  output logic             statIrq,
  output logic [charW-1:0] fwdChar
);

  assign match1 = (rxChar == syncChar1);
  assign match2 = (rxChar == syncChar2);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fwdValid  <= 1'b0;
      dropValid <= 1'b0;
      statIrq   <= 1'b0;
      fwdChar   <= '0;
    end else begin
      fwdValid  <= strobe.fwd;
      dropValid <= strobe.drop;
      statIrq   <= strobe.irq;
      if (strobe.fwd) fwdChar <= rxChar;
    end
  end

  // R8
  one_decision_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({fwdValid, dropValid}));

  // R8
  every_char_decided_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> (fwdValid || dropValid));

  // R8
  no_spurious_decision_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |=> (!fwdValid && !dropValid));

  // R7
  fwd_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && strobe.fwd) |=> (fwdChar == $past(rxChar)));

endmodule

// File: rtl/sync_hunt.sv
module sync_hunt
  import sync_hunt_pkg::*;
#(
  parameter int charW     = 8,
  parameter int ctrlW     = 8,
  parameter int enableBit = 0,
  parameter int huntBit   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chanReset,
  input  logic [3:0]       modeField,
  input  logic             ctrlWe,
  input  logic [ctrlW-1:0] ctrlData,
  input  logic [charW-1:0] syncChar1,
  input  logic [charW-1:0] syncChar2,
  input  logic             dropSync,
  input  logic             statPending,
  input  logic             rxValid,
  input  logic [charW-1:0] rxChar,
  output logic             inHunt,
  output logic             syncPinN,
  output logic             statIrq,
  output logic             fwdValid,
  output logic             dropValid,
  output logic [charW-1:0] fwdChar
);

  huntStrobe_t strobe;
  logic match1, match2;

  sync_hunt_ctrl #(
    .ctrlW(ctrlW), .enableBit(enableBit), .huntBit(huntBit)
  ) ctrlInst (
    .clk(clk), .rstN(rstN), .chanReset(chanReset), .modeField(modeField),
    .ctrlWe(ctrlWe), .ctrlData(ctrlData), .dropSync(dropSync),
    .statPending(statPending), .rxValid(rxValid), .match1(match1),
    .match2(match2), .strobe(strobe), .inHunt(inHunt), .syncPinN(syncPinN)
  );

  sync_hunt_datapath #(.charW(charW)) dpInst (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxChar(rxChar),
    .syncChar1(syncChar1), .syncChar2(syncChar2), .strobe(strobe),
    .match1(match1), .match2(match2), .fwdValid(fwdValid),
    .dropValid(dropValid), .statIrq(statIrq), .fwdChar(fwdChar)
  );

  // R6
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    statIrq |-> ($past(rxValid) && $past(inHunt) && !$past(statPending)));

  // R6
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statIrq && !$past(ctrlWe)) |=> !statIrq);

endmodule

// File: tb/sync_hunt_test.sv
module sync_hunt_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       chanReset = 1'b0;
  logic [3:0] modeField = 4'b0000;
  logic       ctrlWe = 1'b0;
  logic [7:0] ctrlData = 8'h00;
  logic [7:0] syncChar1 = 8'h16;
  logic [7:0] syncChar2 = 8'h00;
  logic       dropSync = 1'b0;
  logic       statPending = 1'b0;
  logic       rxValid = 1'b0;
  logic [7:0] rxChar = 8'h00;
  logic       inHunt, syncPinN, statIrq, fwdValid, dropValid;
  logic [7:0] fwdChar;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  sync_hunt uut (
    .clk(clk), .rstN(rstN), .chanReset(chanReset), .modeField(modeField),
    .ctrlWe(ctrlWe), .ctrlData(ctrlData), .syncChar1(syncChar1),
    .syncChar2(syncChar2), .dropSync(dropSync), .statPending(statPending),
    .rxValid(rxValid), .rxChar(rxChar), .inHunt(inHunt), .syncPinN(syncPinN),
    .statIrq(statIrq), .fwdValid(fwdValid), .dropValid(dropValid),
    .fwdChar(fwdChar)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one control write; result visible at the next falling edge
  task automatic ctrlWrite(input logic [7:0] d);
    @(negedge clk);
    ctrlWe = 1'b1; ctrlData = d;
    @(negedge clk);
    ctrlWe = 1'b0; ctrlData = 8'h00;
  endtask

  // one character; decision visible at the next falling edge
  task automatic pushChar(input logic [7:0] c);
    @(negedge clk);
    rxValid = 1'b1; rxChar = c;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic expectDecision(input string req, input logic f, input logic d,
                                input logic irq);
    chk({req, " fwd"}, fwdValid, f);
    chk({req, " drop"}, dropValid, d);
    chk({req, " irq"}, statIrq, irq);
  endtask

  task automatic t_reset;
    chk("R11 inHunt", inHunt, 0);
    chk("R11 syncPinN", syncPinN, 1);
    expectDecision("R11", 0, 0, 0);
  endtask

  task automatic t_idle;
    modeField = 4'b0000;
    pushChar(8'h55);
    expectDecision("R7", 1, 0, 0);
    chk("R7 data", fwdChar, 8'h55);
    @(negedge clk);
    expectDecision("R8 quiet", 0, 0, 0);
    ctrlWrite(8'h01);
    chk("R1 enable only", inHunt, 0);
    ctrlWrite(8'h10);
    chk("R1 hunt only", inHunt, 0);
  endtask

  task automatic t_mono;
    modeField = 4'b0000; syncChar1 = 8'h16; dropSync = 1'b0;
    ctrlWrite(8'h11);
    chk("R1 inHunt", inHunt, 1);
    chk("R1 syncPinN", syncPinN, 0);
    pushChar(8'h20);
    expectDecision("R2 miss", 0, 1, 0);
    chk("R2 still hunting", inHunt, 1);
    pushChar(8'h16);
    expectDecision("R5 keep", 1, 0, 1);
    chk("R5 data", fwdChar, 8'h16);
    chk("R6 inHunt", inHunt, 0);
    chk("R6 syncPinN", syncPinN, 1);
    @(negedge clk);
    chk("R6 pulse width", statIrq, 0);
    pushChar(8'h16);
    expectDecision("R7 after sync", 1, 0, 0);
  endtask

  task automatic t_monoDrop;
    modeField = 4'b0000; dropSync = 1'b1;
    ctrlWrite(8'h11);
    pushChar(8'h16);
    expectDecision("R5 drop", 0, 1, 1);
    chk("R5 inHunt", inHunt, 0);
    dropSync = 1'b0;
  endtask

  task automatic t_pending;
    modeField = 4'b0000; statPending = 1'b1;
    ctrlWrite(8'h11);
    pushChar(8'h16);
    expectDecision("R6 pending", 1, 0, 0);
    chk("R6 pending inHunt", inHunt, 0);
    statPending = 1'b0;
  endtask

  task automatic t_bi;
    modeField = 4'b0100; syncChar1 = 8'hA5; syncChar2 = 8'h5A;
    ctrlWrite(8'h11);
    pushChar(8'hA5);
    expectDecision("R3 first", 0, 1, 0);
    chk("R3 waiting", inHunt, 1);
    pushChar(8'h5A);
    expectDecision("R3 second", 1, 0, 1);
    chk("R3 done", inHunt, 0);
  endtask

  task automatic t_biFallback;
    modeField = 4'b0100;
    ctrlWrite(8'h11);
    pushChar(8'hA5);
    expectDecision("R4 first", 0, 1, 0);
    pushChar(8'hA5);
    expectDecision("R4 miss", 0, 1, 0);
    pushChar(8'h5A);
    expectDecision("R4 restart", 0, 1, 0);
    chk("R4 hunting", inHunt, 1);
    pushChar(8'hA5);
    expectDecision("R4 first again", 0, 1, 0);
    pushChar(8'h5A);
    expectDecision("R4 done", 1, 0, 1);
  endtask

  task automatic t_async;
    modeField = 4'b0100;
    ctrlWrite(8'h11);
    chk("R9 pre", inHunt, 1);
    @(negedge clk);
    modeField = 4'b0001;
    @(negedge clk);
    chk("R9 mode inHunt", inHunt, 0);
    chk("R9 mode syncPinN", syncPinN, 1);
    ctrlWrite(8'h11);
    chk("R9 cmd ignored", inHunt, 0);
    pushChar(8'hA5);
    expectDecision("R7 async", 1, 0, 0);
  endtask

  task automatic t_chanReset;
    modeField = 4'b0000;
    ctrlWrite(8'h11);
    @(negedge clk);
    chanReset = 1'b1;
    @(negedge clk);
    chanReset = 1'b0;
    chk("R9 reset inHunt", inHunt, 0);
    chk("R9 reset syncPinN", syncPinN, 1);
  endtask

  task automatic t_same;
    modeField = 4'b0000; syncChar1 = 8'h16;
    ctrlWrite(8'h11);
    @(negedge clk);
    rxValid = 1'b1; rxChar = 8'h16; ctrlWe = 1'b1; ctrlData = 8'h11;
    @(negedge clk);
    rxValid = 1'b0; ctrlWe = 1'b0; ctrlData = 8'h00;
    expectDecision("R10 hunting", 1, 0, 1);
    chk("R10 rehunt", inHunt, 1);
    chanReset = 1'b1;
    @(negedge clk);
    chanReset = 1'b0;
    @(negedge clk);
    rxValid = 1'b1; rxChar = 8'h16; ctrlWe = 1'b1; ctrlData = 8'h11;
    @(negedge clk);
    rxValid = 1'b0; ctrlWe = 1'b0; ctrlData = 8'h00;
    expectDecision("R10 idle", 1, 0, 0);
    chk("R10 enters", inHunt, 1);
  endtask

  initial begin
    #20000;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rstN = 1'b1;
    @(negedge clk);
    t_idle;
    t_mono;
    t_monoDrop;
    t_pending;
    t_bi;
    t_biFallback;
    t_async;
    t_chanReset;
    t_same;
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule